// File: doc/BRIEF.md
# Table-Based Arbitrary Waveform Sequencer

This block produces a stream of 10-bit samples for a parallel-input digital-to-analog converter. The samples come from a writable table that holds one full period of the wanted waveform. A host loads the table, and the table, the address logic and the sample output all run on the converter's sample clock.

The table can be played back in two ways. In counter mode a plain address counter moves through the table one entry per clock. In phase mode a 24-bit phase accumulator adds a programmable increment on every clock, and its top ten bits pick the table entry. The output frequency therefore scales with the increment. A change of mode restarts playback from entry zero. The run input pauses playback without losing position. A new increment changes the frequency without a jump in phase.

Top module: `awg_sequencer`

## Requirements
- R1: While rst_n is low at a rising clock edge, the design clears sample to 0 and sample_vld to 0, and it clears the address, the phase and the increment to 0 and the recorded mode to counter.
- R2: In counter mode (mode = 0) with run high, successive valid samples are table entries 0, 1, 2, and so on, one per clock. After entry 1023 the sequence wraps to entry 0.
- R3: In phase mode (mode = 1) with run high, the accumulator grows by the increment register on every clock, modulo 2^24. Each sample is the table entry addressed by accumulator bits [23:14].
- R4: A table read happens on each clock edge at which run is high. Its data appears on sample after that same edge, with sample_vld high. sample_vld is high only in cycles that carry a freshly read sample.
- R5: While run is low, the address and the phase stay frozen, sample keeps its last value and sample_vld is low. When run goes high again, playback continues from the frozen position.
- R6: A clock edge at which mode differs from the mode recorded at the previous edge resets the address and the phase to zero. That edge produces no sample, so sample_vld is low and sample is held. The next sample read is table entry 0.
- R7: An increment written with inc_we is used from the accumulator update at the following edge onward. The accumulated phase is not reset.
- R8: A table write with tbl_we is accepted at any time. If a read of the same address happens at the same edge, the read returns the old content. Later reads return the new content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock shared with the converter |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 1 | Playback mode: 0 counter, 1 phase accumulator |
| run | input | 1 | High to read one table entry per clock |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | 10 | Table write address |
| tbl_wdata | input | 10 | Table write data |
| inc_we | input | 1 | Increment register write strobe |
| inc_wdata | input | 24 | New phase increment |
| sample | output | 10 | Registered sample to the converter |
| sample_vld | output | 1 | High when sample was read at the last edge |

## Verification
The hardest cases to reach from the ports are a table write that hits the exact entry being read at the same edge, and an increment change that lands between two accumulator updates. The bench reaches both by counting edges from a known zero position. Before each run it toggles mode twice with run low, which puts the address and the phase at zero. It then places the table write or the increment write on the negative edge just before the chosen read, and compares the resulting addresses with a simple model of the phase in the bench. Wrap-around is forced in two ways: a counter run long enough to cross entry 1023, and a phase increment of 0xFFC000, which steps backwards through the table.

// File: rtl/awg_pkg.sv
// Shared types for the waveform sequencer.
// Assumes: the mode encoding below matches the value on the top-level mode pin.
package awg_pkg;
    typedef enum logic {
        SEQ_COUNT = 1'b0,
        SEQ_PHASE = 1'b1
    } seq_mode_e;
endpackage

// File: rtl/awg_wave_ram.sv
// Waveform table: one write port and one synchronous read port.
// The read register is the sample register, so read latency is one clock.
// Assumes: a read and a write of the same address at the same edge return the old data.
module awg_wave_ram #(
    parameter int SAMPLE_W = 10,
    parameter int ADDR_W   = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   waddr,
    input  logic [SAMPLE_W-1:0] wdata,
    input  logic                re,
    input  logic [ADDR_W-1:0]   raddr,
    output logic [SAMPLE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [SAMPLE_W-1:0] mem [DEPTH];
    logic [SAMPLE_W-1:0] rdata_q;

    // Host write into the table (contents are not reset)
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read that holds its value when no read is issued
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (re) begin
            rdata_q <= mem[raddr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/awg_addr_gen.sv
// Address generator: a linear counter or a phase accumulator selects the table entry.
// A mode change clears both positions and suppresses the read at that edge.
// Assumes: PHASE_W >= ADDR_W; the increment register updates independently of run.
module awg_addr_gen
    import awg_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int PHASE_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  seq_mode_e          mode,
    input  logic               run,
    input  logic               inc_we,
    input  logic [PHASE_W-1:0] inc_wdata,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  rd_addr
);
    localparam int FRAC_W = PHASE_W - ADDR_W;

    seq_mode_e          mode_q;
    logic [ADDR_W-1:0]  cnt_q;
    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] inc_q;
    logic               switch_now;
    logic [ADDR_W-1:0]  phase_addr;

    // A mode different from the one recorded at the last edge is a switch
    assign switch_now = (mode != mode_q);

    // Table index taken from the top of the accumulator
    generate
        if (FRAC_W > 0) begin : g_frac
            assign phase_addr = phase_q[PHASE_W-1 -: ADDR_W];
        end else begin : g_nofrac
            assign phase_addr = phase_q[ADDR_W-1:0];
        end
    endgenerate

    // Read strobe and address seen by the table
    always_comb begin
        rd_en   = run && !switch_now;
        rd_addr = (mode_q == SEQ_PHASE) ? phase_addr : cnt_q;
    end

    // Increment register, used from the next accumulator update onward
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_q <= '0;
        end else if (inc_we) begin
            inc_q <= inc_wdata;
        end
    end

    // Mode record and position update: cleared on a switch, frozen while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= SEQ_COUNT;
            cnt_q   <= '0;
            phase_q <= '0;
        end else begin
            mode_q <= mode;
            if (switch_now) begin
                cnt_q   <= '0;
                phase_q <= '0;
            end else if (run) begin
                if (mode_q == SEQ_PHASE) begin
                    phase_q <= phase_q + inc_q;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/awg_sequencer.sv
// Top level of the waveform sequencer: address generator, table and valid strobe.
// sample_vld is registered at the same edge as the table read, so it lines up with sample.
// Assumes: every port is synchronous to clk.
module awg_sequencer
    import awg_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int ADDR_W   = 10,
    parameter int PHASE_W  = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode,
    input  logic                run,
    input  logic                tbl_we,
    input  logic [ADDR_W-1:0]   tbl_waddr,
    input  logic [SAMPLE_W-1:0] tbl_wdata,
    input  logic                inc_we,
    input  logic [PHASE_W-1:0]  inc_wdata,
    output logic [SAMPLE_W-1:0] sample,
    output logic                sample_vld
);
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic              vld_q;

    awg_addr_gen #(
        .ADDR_W  (ADDR_W),
        .PHASE_W (PHASE_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (seq_mode_e'(mode)),
        .run       (run),
        .inc_we    (inc_we),
        .inc_wdata (inc_wdata),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr)
    );

    awg_wave_ram #(
        .SAMPLE_W (SAMPLE_W),
        .ADDR_W   (ADDR_W)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_waddr),
        .wdata (tbl_wdata),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (sample)
    );

    // Valid strobe registered alongside the table read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else begin
            vld_q <= rd_en;
        end
    end

    assign sample_vld = vld_q;
endmodule

// File: rtl/awg_sequencer_chk.sv
// Port-level temporal checks for the waveform sequencer, bound to every instance.
// Assumes: reset is held for at least two clocks at start-up.
module awg_sequencer_chk #(
    parameter int SAMPLE_W = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mode,
    input logic                run,
    input logic [SAMPLE_W-1:0] sample,
    input logic                sample_vld
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (sample == '0 && !sample_vld));

    // R4
    vld_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> $past(run));

    // R5
    stop_drops_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sample_vld);

    // R5
    hold_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |-> $stable(sample));

    // R6
    mode_switch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |=> !sample_vld);
endmodule

bind awg_sequencer awg_sequencer_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .run        (run),
    .sample     (sample),
    .sample_vld (sample_vld)
);

// File: tb/awg_sequencer_test.sv
module awg_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 10;
    localparam int AW = 10;
    localparam int PW = 24;

    typedef struct packed {
        logic          mode;
        logic [PW-1:0] inc;
        logic [5:0]    steps;
    } vec_t;

    // Playback vectors: mode, increment, number of samples compared to the model
    localparam vec_t VECS [6] = '{
        '{1'b0, 24'h000000, 6'd10},
        '{1'b1, 24'h004000, 6'd10},
        '{1'b1, 24'h000100, 6'd8},
        '{1'b1, 24'h012345, 6'd20},
        '{1'b1, 24'hFFC000, 6'd6},
        '{1'b1, 24'h800000, 6'd5}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mode;
    logic          run;
    logic          tbl_we;
    logic [AW-1:0] tbl_waddr;
    logic [SW-1:0] tbl_wdata;
    logic          inc_we;
    logic [PW-1:0] inc_wdata;
    logic [SW-1:0] sample;
    logic          sample_vld;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    awg_sequencer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .run        (run),
        .tbl_we     (tbl_we),
        .tbl_waddr  (tbl_waddr),
        .tbl_wdata  (tbl_wdata),
        .inc_we     (inc_we),
        .inc_wdata  (inc_wdata),
        .sample     (sample),
        .sample_vld (sample_vld)
    );

    function automatic logic [SW-1:0] tv(int i);
        return SW'((i * 37 + 11) % 1024);
    endfunction

    task automatic chk(string tag, logic [SW-1:0] exp_s, logic exp_v);
        n_run++;
        if (sample !== exp_s || sample_vld !== exp_v) begin
            n_fail++;
            $display("FAIL %s: sample=%0h vld=%0b, expected sample=%0h vld=%0b",
                     tag, sample, sample_vld, exp_s, exp_v);
        end
    endtask

    // Two mode changes with run low leave address and phase at zero in mode m
    task automatic restart(logic m);
        run  = 1'b0;
        mode = ~m;
        @(negedge clk);
        mode = m;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; mode = 1'b0; run = 1'b0; tbl_we = 1'b0;
        tbl_waddr = '0; tbl_wdata = '0; inc_we = 1'b0; inc_wdata = '0;
        repeat (5) @(negedge clk);
        chk("R1 reset", '0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < 1024; i++) begin
            tbl_we = 1'b1; tbl_waddr = AW'(i); tbl_wdata = tv(i);
            @(negedge clk);
        end
        tbl_we = 1'b0;
        chk("R1 idle after reset", '0, 1'b0);

        // Vector walk: R2 counter, R3 phase accumulation, R4 alignment
        for (int v = 0; v < 6; v++) begin
            logic [PW-1:0] ph;
            int            cnt;
            inc_we = 1'b1; inc_wdata = VECS[v].inc;
            restart(VECS[v].mode);
            inc_we = 1'b0;
            ph = '0; cnt = 0;
            run = 1'b1;
            for (int s = 0; s < int'(VECS[v].steps); s++) begin
                @(negedge clk);
                if (VECS[v].mode) chk("R3 R4 vector", tv(int'(ph[PW-1 -: AW])), 1'b1);
                else              chk("R2 R4 vector", tv(cnt % 1024), 1'b1);
                ph = ph + VECS[v].inc;
                cnt++;
            end
            run = 1'b0;
            @(negedge clk);
        end

        // R2: counter wrap after entry 1023
        restart(1'b0);
        run = 1'b1;
        for (int k = 0; k < 1026; k++) begin
            @(negedge clk);
            chk("R2 wrap", tv(k % 1024), 1'b1);
        end

        // R5: freeze and resume
        restart(1'b0);
        run = 1'b1;
        repeat (5) @(negedge clk);
        run = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R5 frozen", tv(4), 1'b0);
        end
        run = 1'b1;
        @(negedge clk);
        chk("R5 resume", tv(5), 1'b1);

        // R6: mode change while running
        inc_we = 1'b1; inc_wdata = 24'h004000;
        restart(1'b1);
        inc_we = 1'b0;
        run = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R6 before switch", tv(k), 1'b1);
        end
        mode = 1'b0;
        @(negedge clk);
        chk("R6 switch gap", tv(2), 1'b0);
        @(negedge clk);
        chk("R6 restart at 0", tv(0), 1'b1);
        @(negedge clk);
        chk("R6 next", tv(1), 1'b1);

        // R7: increment change while running keeps phase
        inc_we = 1'b1; inc_wdata = 24'h004000;
        restart(1'b1);
        inc_we = 1'b0;
        run = 1'b1;
        repeat (3) @(negedge clk);
        inc_we = 1'b1; inc_wdata = 24'h00C000;
        @(negedge clk);
        inc_we = 1'b0;
        chk("R7 old step", tv(3), 1'b1);
        @(negedge clk);
        chk("R7 last old", tv(4), 1'b1);
        @(negedge clk);
        chk("R7 new step", tv(7), 1'b1);
        @(negedge clk);
        chk("R7 new step", tv(10), 1'b1);

        // R8: table write colliding with a read, then visible on the next pass
        restart(1'b0);
        run = 1'b1;
        @(negedge clk);
        chk("R8 pre", tv(0), 1'b1);
        @(negedge clk);
        chk("R8 pre", tv(1), 1'b1);
        tbl_we = 1'b1; tbl_waddr = 10'd2; tbl_wdata = 10'h155;
        @(negedge clk);
        tbl_we = 1'b0;
        chk("R8 same-edge old data", tv(2), 1'b1);
        restart(1'b0);
        run = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R8 new data", (k == 2) ? 10'h155 : tv(k), 1'b1);
        end
        run = 1'b0;
        tbl_we = 1'b1; tbl_waddr = 10'd2; tbl_wdata = tv(2);
        @(negedge clk);
        tbl_we = 1'b0;
        @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule